// File: doc/BRIEF.md
# Split high/low-time clock divider

This block divides a reference clock by an integer ratio between 1 and 126. The ratio is not given as one number. It is given as two 6-bit phase lengths: a high-time count and a low-time count. The output stays high for the high count of input cycles, then low for the low count, so the period is their sum.

For odd ratios the low count is one larger than the high count. A companion odd flag moves the falling output edge half an input cycle later, using a flop clocked on the falling input edge, so the duty cycle comes out even. A bypass flag routes the input clock straight to the output and forces a ratio of 1, whatever the counts say.

New settings are taken only on the last input cycle of an output period, so a change of ratio never produces a runt pulse. A hold input suppresses that load. A zero ratio parks the output low and raises an error flag.

Top module: `clkdiv_hl`

## Requirements
- R1: With bypass and odd clear in the active setting, and the ratio N = high + low nonzero, the output repeats a period of N input cycles. It is high for the first `high` cycles and low for the remaining `low` cycles, and any combination of counts, including 63/63, is honoured.
- R2: With the odd flag set and `high` nonzero, the output falls half an input cycle later than it would under R1: it stays high through the first half of the first low cycle. A standard odd encoding (high = floor(N/2), low = ceil(N/2)) thus gives high and low times of N/2 input cycles each.
- R3: With bypass set in the active setting, the output equals the input clock and the error flag is low, whatever the two counts hold.
- R4: Input settings are loaded only on a period boundary: the last cycle of an output period, or any cycle while bypass is active or the ratio is zero. The loaded setting governs the following cycle, which begins a new period with its high phase. A change on the inputs in mid-period has no effect on the current period.
- R5: While `hold_i` is high, a period boundary keeps the active setting and the next period repeats the old setting.
- R6: An active setting with bypass clear and both counts zero holds the output low and drives `zero_err_o` high.
- R7: An active-low asynchronous reset forces the output low and clears the active setting, so `zero_err_o` reads 1 during reset. Reset must be released synchronously to `clk_i`. The first rising edge after release loads the inputs, and the output starts the high phase in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lo_cnt_i | input | 6 | Low-phase length in input cycles |
| hi_cnt_i | input | 6 | High-phase length in input cycles |
| odd_i | input | 1 | Half-cycle stretch of the high phase for odd ratios |
| bypass_i | input | 1 | Pass the reference clock through (ratio 1) |
| hold_i | input | 1 | Keep the active setting at the next boundary |
| clk_o | output | 1 | Divided clock |
| zero_err_o | output | 1 | Active ratio is zero |

## Verification
The assertions take the setting inputs and `hold_i` to be steady around each rising edge of the reference clock. They also take reset release to be synchronous, since the period counter and the falling-edge stretch flop both assume a full cycle after release. The stimulus changes settings, hold and reset only a quarter period after a falling edge, so every rising edge sees settled values. Settings are often changed in mid-period, to exercise the boundary-only loading.

// File: rtl/clkdiv_hl_pkg.sv
package clkdiv_hl_pkg;
  localparam int CNT_W   = 6;
  localparam int RATIO_W = CNT_W + 1;

  typedef struct packed {
    logic             bypass;
    logic             odd;
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
  } div_set_t;
endpackage

// File: rtl/clkdiv_hl_shadow.sv
module clkdiv_hl_shadow
  import clkdiv_hl_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wrap_i,
  input  logic     hold_i,
  input  div_set_t set_i,
  output div_set_t set_nx_o,
  output div_set_t set_q_o
);
  div_set_t set_q, set_nx;
  logic     load_en;

  always_comb begin
    load_en = wrap_i && !hold_i;
    set_nx  = set_q;
    if (load_en) set_nx = set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) set_q <= '0;
    else         set_q <= set_nx;
  end

  assign set_nx_o = set_nx;
  assign set_q_o  = set_q;

  // R4: the active setting moves only after a boundary without hold
  p_load_at_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_q != $past(set_q)) |-> ($past(wrap_i) && !$past(hold_i)));

  // R5: hold freezes the active setting
  p_hold_keeps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hold_i) |-> (set_q == $past(set_q)));
endmodule

// File: rtl/clkdiv_hl_count.sv
module clkdiv_hl_count
  import clkdiv_hl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   hi_q_i,
  input  logic [CNT_W-1:0]   lo_q_i,
  input  logic               byp_q_i,
  input  logic [CNT_W-1:0]   hi_nx_i,
  input  logic [CNT_W-1:0]   lo_nx_i,
  input  logic               byp_nx_i,
  output logic               wrap_o,
  output logic [RATIO_W-1:0] pos_o,
  output logic               lvl_o
);
  logic [RATIO_W-1:0] pos_q, pos_nx;
  logic [RATIO_W-1:0] ratio_q, ratio_nx;
  logic               lvl_q, lvl_nx;
  logic               wrap;

  always_comb begin
    ratio_q  = {1'b0, hi_q_i} + {1'b0, lo_q_i};
    ratio_nx = {1'b0, hi_nx_i} + {1'b0, lo_nx_i};
    wrap     = byp_q_i || (ratio_q == '0) || (pos_q == ratio_q - 1'b1);
    pos_nx   = wrap ? '0 : pos_q + 1'b1;
    lvl_nx   = !byp_nx_i && (ratio_nx != '0) && (pos_nx < {1'b0, hi_nx_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      pos_q <= pos_nx;
      lvl_q <= lvl_nx;
    end
  end

  assign wrap_o = wrap;
  assign pos_o  = pos_q;
  assign lvl_o  = lvl_q;

  // R1: position stays inside the period
  p_pos_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp_q_i && ratio_q != '0) |-> (pos_q < ratio_q));

  // R4: every period opens with its high phase
  p_start_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp_q_i && pos_q == '0 && hi_q_i != '0) |-> lvl_q);
endmodule

// File: rtl/clkdiv_hl_halfext.sv
module clkdiv_hl_halfext
  import clkdiv_hl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lvl_i,
  input  logic [RATIO_W-1:0] pos_i,
  input  logic [CNT_W-1:0]   hi_i,
  input  logic               odd_i,
  output logic               ext_o
);
  logic ext_q, ext_nx;

  always_comb begin
    ext_nx = lvl_i && odd_i && ((pos_i + 1'b1) == {1'b0, hi_i});
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= 1'b0;
    else         ext_q <= ext_nx;
  end

  assign ext_o = ext_q;

  // R2: the stretch is armed only while the odd setting is in its high phase
  p_ext_needs_odd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_q |-> (lvl_i && odd_i));
endmodule

// File: rtl/clkdiv_hl.sv
module clkdiv_hl
  import clkdiv_hl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] lo_cnt_i,
  input  logic [CNT_W-1:0] hi_cnt_i,
  input  logic             odd_i,
  input  logic             bypass_i,
  input  logic             hold_i,
  output logic             clk_o,
  output logic             zero_err_o
);
  div_set_t           set_in, set_q, set_nx;
  logic               wrap, lvl, ext;
  logic [RATIO_W-1:0] pos;

  always_comb begin
    set_in.bypass = bypass_i;
    set_in.odd    = odd_i;
    set_in.hi     = hi_cnt_i;
    set_in.lo     = lo_cnt_i;
  end

  clkdiv_hl_shadow u_shadow (
    .clk_i, .rst_ni,
    .wrap_i   (wrap),
    .hold_i   (hold_i),
    .set_i    (set_in),
    .set_nx_o (set_nx),
    .set_q_o  (set_q)
  );

  clkdiv_hl_count u_count (
    .clk_i, .rst_ni,
    .hi_q_i   (set_q.hi),
    .lo_q_i   (set_q.lo),
    .byp_q_i  (set_q.bypass),
    .hi_nx_i  (set_nx.hi),
    .lo_nx_i  (set_nx.lo),
    .byp_nx_i (set_nx.bypass),
    .wrap_o   (wrap),
    .pos_o    (pos),
    .lvl_o    (lvl)
  );

  clkdiv_hl_halfext u_halfext (
    .clk_i, .rst_ni,
    .lvl_i (lvl),
    .pos_i (pos),
    .hi_i  (set_q.hi),
    .odd_i (set_q.odd),
    .ext_o (ext)
  );

  assign clk_o      = set_q.bypass ? clk_i : (lvl | ext);
  assign zero_err_o = !set_q.bypass && (set_q.hi == '0) && (set_q.lo == '0);

  // R6: a zero ratio keeps the output parked low
  p_zero_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_err_o |-> !clk_o);

  // R3: bypass never reports an error
  p_bypass_noerr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wrap && bypass_i && !hold_i) |-> !zero_err_o);
endmodule

// File: tb/tb_clkdiv_hl.sv
module tb_clkdiv_hl;
  localparam int T = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] lo_cnt_i = '0, hi_cnt_i = '0;
  logic       odd_i = 1'b0, bypass_i = 1'b0, hold_i = 1'b0;
  logic       clk_o, zero_err_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_hi = 0, m_lo = 0, m_p = 0;
  bit m_odd = 0, m_byp = 0, m_ext = 0;
  bit e1, e2, eerr;

  always #(T/2) clk_i = ~clk_i;

  clkdiv_hl dut (
    .clk_i, .rst_ni, .lo_cnt_i, .hi_cnt_i, .odd_i,
    .bypass_i, .hold_i, .clk_o, .zero_err_o
  );

  task automatic check(input bit act, input bit exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: got %0b expected %0b", tag, what, $time, act, exp);
    end
  endtask

  task automatic model_step();
    int n;
    bit bnd, lvl;
    if (!rst_ni) begin
      m_hi = 0; m_lo = 0; m_p = 0; m_odd = 0; m_byp = 0; m_ext = 0;
    end else begin
      n = m_hi + m_lo;
      bnd = m_byp || n == 0 || m_p == n - 1;
      m_ext = !m_byp && n != 0 && m_odd && m_hi > 0 && m_p == m_hi - 1;
      if (bnd) begin
        if (!hold_i) begin
          m_hi = hi_cnt_i; m_lo = lo_cnt_i; m_odd = odd_i; m_byp = bypass_i;
        end
        m_p = 0;
      end else m_p++;
    end
    n    = m_hi + m_lo;
    lvl  = !m_byp && n != 0 && m_p < m_hi;
    e1   = m_byp ? 1'b1 : (lvl || m_ext);
    e2   = m_byp ? 1'b0 : lvl;
    eerr = !m_byp && n == 0;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      model_step();
      #(T/4);
      check(clk_o, e1, tag, "clk_o first half");
      check(zero_err_o, eerr, tag, "zero_err_o");
      @(negedge clk_i);
      #(T/4);
      check(clk_o, e2, tag, "clk_o second half");
    end
  endtask

  task automatic set_cfg(input int hi, input int lo, input bit odd, input bit byp);
    hi_cnt_i = 6'(hi); lo_cnt_i = 6'(lo); odd_i = odd; bypass_i = byp;
  endtask

  initial begin
    set_cfg(2, 2, 0, 0);
    run(4, "R7");                      // R7: reset state, output low, error set
    rst_ni = 1'b1;
    run(12, "R1");                     // R1: divide by 4
    set_cfg(1, 3, 0, 0);
    run(16, "R4");                     // R4: change mid-period, boundary load
    set_cfg(2, 3, 1, 0);
    run(20, "R2");                     // R2: divide by 5, even duty
    set_cfg(6, 7, 1, 0);
    run(40, "R2");                     // R2: divide by 13
    hold_i = 1'b1; set_cfg(3, 3, 0, 0);
    run(30, "R5");                     // R5: old 6/7 kept
    hold_i = 1'b0;
    run(20, "R4");                     // R4: 3/3 taken at boundary
    set_cfg(0, 1, 0, 1);
    run(10, "R3");                     // R3: bypass, ratio 1
    set_cfg(5, 9, 0, 1);
    run(8, "R3");                      // R3: counts ignored under bypass
    set_cfg(0, 0, 0, 0);
    run(8, "R6");                      // R6: zero ratio
    set_cfg(3, 2, 1, 0);
    run(16, "R4");                     // R4: recovery starts with high phase
    set_cfg(4, 1, 0, 0);
    run(15, "R1");                     // R1: unequal phases
    set_cfg(63, 63, 0, 0);
    run(270, "R1");                    // R1: largest ratio
    rst_ni = 1'b0;
    run(3, "R7");                      // R7: asynchronous reset mid-run
    set_cfg(2, 3, 1, 0);
    rst_ni = 1'b1;
    run(12, "R7");                     // R7: restart with high phase
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule